// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Engine

This block is the arithmetic back end of a 16-bit signal-processing core. Each cycle in which an operation is strobed, it forms a full-precision product of two 16-bit operands, or combines or shifts 40-bit values, and writes the result into one of two 40-bit accumulators. Each operand is flagged signed or unsigned on its own, so signed, unsigned and mixed-sign products all come out exact. In fractional mode the product of two 1.15 numbers is doubled to 1.31 alignment, and the corner case of negative one squared is represented exactly.

Every accumulator holds 8 guard bits above a 32-bit result. A per-operation saturation enable chooses between clamping at the 40-bit limits and modular wrap. Two sticky flags per accumulator record results that spill into the guard bits and results that were clamped. A single-cycle bidirectional shifter moves an accumulator by up to 16 places. Operand fetch, address generation and instruction decode are left to the surrounding core.

Top module: `dsp_mac_engine`

## Requirements
- R1: While rst_ni is low, both accumulators read zero and all four flags read zero.
- R2: Each operand is sign-extended to 17 bits when its signed select is 1 and zero-extended when it is 0. Opcode 2'b01 (multiply) writes the exact product, sign-extended to 40 bits, into the selected accumulator.
- R3: With frac_i = 1 the product is doubled before use, so signed 0x8000 times signed 0x8000 gives 0x00_8000_0000.
- R4: Opcode 2'b00 (multiply-accumulate) writes accumulator + product, or accumulator - product when sub_i = 1, in the same cycle. The accumulator that is not selected is unchanged. acc_sel_i = 0 selects acc_o[39:0] and acc_sel_i = 1 selects acc_o[79:40].
- R5: Opcode 2'b10 (accumulator add) writes the selected accumulator plus the other accumulator, or minus it when sub_i = 1.
- R6: With sat_en_i = 1, a sum or difference for opcodes 2'b00 or 2'b10 that leaves the 40-bit signed range is clamped to 0x7F_FFFF_FFFF or 0x80_0000_0000. The accumulator's bit in sat_o (bit 0 for acc 0) is then set, and it stays set until reset.
- R7: With sat_en_i = 0, such a result wraps modulo 2^40 and sat_o does not change.
- R8: Opcode 2'b11 (shift) shifts the selected accumulator by the two's-complement 6-bit shamt_i. A positive amount gives an arithmetic right shift and a negative amount gives a left shift. Magnitudes above 16 act as 16. A left shift that leaves the 40-bit range clamps and sets sat_o when sat_en_i = 1, and truncates when it is 0.
- R9: The accumulator's bit in ovf_o is set when a value written to that accumulator has bits 39..31 not all equal, and it stays set until reset.
- R10: While valid_i = 0, accumulators and flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 2 | 00 MAC, 01 MPY, 10 ADD, 11 SHIFT |
| acc_sel_i | input | 1 | Destination accumulator |
| a_i | input | 16 | Operand A |
| b_i | input | 16 | Operand B |
| a_signed_i | input | 1 | Operand A is signed |
| b_signed_i | input | 1 | Operand B is signed |
| frac_i | input | 1 | Fractional product alignment |
| sub_i | input | 1 | Subtract instead of add |
| sat_en_i | input | 1 | Clamp instead of wrap |
| shamt_i | input | 6 | Signed shift amount |
| acc_o | output | 80 | Accumulator 1 in [79:40], accumulator 0 in [39:0] |
| ovf_o | output | 2 | Sticky guard-bit overflow per accumulator |
| sat_o | output | 2 | Sticky saturation per accumulator |

## Verification
The assertions watch, on every cycle, the properties that need no arithmetic model: state holds while idle, the unselected accumulator holds, both flag sets are sticky, the saturation flag never moves with clamping off, a newly set saturation flag comes with a limit value and a guard overflow, and the fractional negative-one square. Exact product values under each signedness mix, add and subtract results, wrap against clamp, and shift results at the clamped magnitudes can only be shown by the bench. The bench compares every accumulator and flag against its own arithmetic model after directed corner cases and a long seeded random mix of operations.

// File: rtl/dsp_mac_pkg.sv
package dsp_mac_pkg;
  localparam int DW    = 16;
  localparam int AW    = 40;
  localparam int SHW   = 6;
  localparam int MAXSH = 16;
  localparam int NACC  = 2;

  typedef enum logic [1:0] {
    OP_MAC = 2'b00,
    OP_MPY = 2'b01,
    OP_ADD = 2'b10,
    OP_SHF = 2'b11
  } op_e;
endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int DW = dsp_mac_pkg::DW,
  parameter int AW = dsp_mac_pkg::AW
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          a_signed_i,
  input  logic          b_signed_i,
  input  logic          frac_i,
  output logic [AW-1:0] prod_o
);
  localparam int PW = 2*DW + 2;

  logic signed [DW:0]   ea, eb;
  logic signed [PW-1:0] p;
  logic signed [AW-1:0] pe;

  always_comb begin
    ea = $signed({a_signed_i & a_i[DW-1], a_i});
    eb = $signed({b_signed_i & b_i[DW-1], b_i});
    p  = ea * eb;
    pe = AW'(p);
    // fractional: 1.15 x 1.15 -> 1.31, exact for -1 x -1 thanks to guard bits
    prod_o = frac_i ? pe <<< 1 : pe;
  end
endmodule

// File: rtl/mac_addsub.sv
module mac_addsub #(
  parameter int AW = dsp_mac_pkg::AW
) (
  input  logic [AW-1:0] x_i,
  input  logic [AW-1:0] y_i,
  input  logic          sub_i,
  input  logic          sat_en_i,
  output logic [AW-1:0] res_o,
  output logic          clamp_o
);
  localparam logic [AW-1:0] MAX_V = {1'b0, {(AW-1){1'b1}}};
  localparam logic [AW-1:0] MIN_V = {1'b1, {(AW-1){1'b0}}};

  logic [AW:0] xe, ye, s;
  logic        wrap;

  always_comb begin
    xe      = {x_i[AW-1], x_i};
    ye      = {y_i[AW-1], y_i};
    s       = sub_i ? xe - ye : xe + ye;
    wrap    = s[AW] ^ s[AW-1];
    clamp_o = wrap & sat_en_i;
    if (clamp_o) res_o = s[AW] ? MIN_V : MAX_V;
    else         res_o = s[AW-1:0];
  end
endmodule

// File: rtl/mac_shifter.sv
module mac_shifter #(
  parameter int AW    = dsp_mac_pkg::AW,
  parameter int SHW   = dsp_mac_pkg::SHW,
  parameter int MAXSH = dsp_mac_pkg::MAXSH
) (
  input  logic [AW-1:0]  x_i,
  input  logic [SHW-1:0] amt_i,
  input  logic           sat_en_i,
  output logic [AW-1:0]  res_o,
  output logic           clamp_o
);
  localparam int EW = AW + MAXSH;
  localparam logic [AW-1:0] MAX_V = {1'b0, {(AW-1){1'b1}}};
  localparam logic [AW-1:0] MIN_V = {1'b1, {(AW-1){1'b0}}};

  logic [SHW-1:0]       mag_raw, mag;
  logic signed [AW-1:0] xs;
  logic [EW-1:0]        wide;
  logic [EW-AW:0]       top;
  logic                 fits;

  always_comb begin
    mag_raw = amt_i[SHW-1] ? -amt_i : amt_i;
    mag     = (mag_raw > SHW'(MAXSH)) ? SHW'(MAXSH) : mag_raw;
    xs      = $signed(x_i);
    wide    = {{MAXSH{x_i[AW-1]}}, x_i} << mag;
    top     = wide[EW-1:AW-1];
    fits    = (&top) | ~(|top);
    clamp_o = 1'b0;
    if (!amt_i[SHW-1]) begin
      res_o = xs >>> mag;
    end else if (!fits && sat_en_i) begin
      res_o   = wide[EW-1] ? MIN_V : MAX_V;
      clamp_o = 1'b1;
    end else begin
      res_o = wide[AW-1:0];
    end
  end
endmodule

// File: rtl/dsp_mac_engine.sv
module dsp_mac_engine
  import dsp_mac_pkg::*;
#(
  parameter int DW    = dsp_mac_pkg::DW,
  parameter int AW    = dsp_mac_pkg::AW,
  parameter int SHW   = dsp_mac_pkg::SHW,
  parameter int MAXSH = dsp_mac_pkg::MAXSH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        op_i,
  input  logic              acc_sel_i,
  input  logic [DW-1:0]     a_i,
  input  logic [DW-1:0]     b_i,
  input  logic              a_signed_i,
  input  logic              b_signed_i,
  input  logic              frac_i,
  input  logic              sub_i,
  input  logic              sat_en_i,
  input  logic [SHW-1:0]    shamt_i,
  output logic [NACC*AW-1:0] acc_o,
  output logic [NACC-1:0]   ovf_o,
  output logic [NACC-1:0]   sat_o
);
  localparam int GB = 2*DW - 1; // lowest bit of the guard-check window

  op_e           op;
  logic [AW-1:0] acc_q [NACC];
  logic [AW-1:0] src, oth, prod, addend, add_res, shf_res, res;
  logic          add_clamp, shf_clamp, clamp, guard_bad;

  assign op     = op_e'(op_i);
  assign src    = acc_q[acc_sel_i];
  assign oth    = acc_q[~acc_sel_i];
  assign addend = (op == OP_ADD) ? oth : prod;

  mac_mult #(.DW(DW), .AW(AW)) u_mult (
    .a_i(a_i), .b_i(b_i), .a_signed_i(a_signed_i), .b_signed_i(b_signed_i),
    .frac_i(frac_i), .prod_o(prod)
  );

  mac_addsub #(.AW(AW)) u_addsub (
    .x_i(src), .y_i(addend), .sub_i(sub_i), .sat_en_i(sat_en_i),
    .res_o(add_res), .clamp_o(add_clamp)
  );

  mac_shifter #(.AW(AW), .SHW(SHW), .MAXSH(MAXSH)) u_shf (
    .x_i(src), .amt_i(shamt_i), .sat_en_i(sat_en_i),
    .res_o(shf_res), .clamp_o(shf_clamp)
  );

  always_comb begin
    unique case (op)
      OP_MPY:  begin res = prod;    clamp = 1'b0;      end
      OP_SHF:  begin res = shf_res; clamp = shf_clamp; end
      default: begin res = add_res; clamp = add_clamp; end
    endcase
    guard_bad = ~((&res[AW-1:GB]) | ~(|res[AW-1:GB]));
  end

  logic [NACC-1:0] ovf_q, sat_q;

  for (genvar g = 0; g < NACC; g++) begin : g_acc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        acc_q[g] <= '0;
        ovf_q[g] <= 1'b0;
        sat_q[g] <= 1'b0;
      end else if (valid_i && (acc_sel_i == 1'(g))) begin
        acc_q[g] <= res;
        ovf_q[g] <= ovf_q[g] | guard_bad;
        sat_q[g] <= sat_q[g] | clamp;
      end
    end
    assign acc_o[g*AW +: AW] = acc_q[g];
  end

  assign ovf_o = ovf_q;
  assign sat_o = sat_q;
endmodule

// File: rtl/dsp_mac_engine_chk.sv
module dsp_mac_engine_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [1:0]  op_i,
  input logic        acc_sel_i,
  input logic [15:0] a_i,
  input logic [15:0] b_i,
  input logic        a_signed_i,
  input logic        b_signed_i,
  input logic        frac_i,
  input logic        sat_en_i,
  input logic [79:0] acc_o,
  input logic [1:0]  ovf_o,
  input logic [1:0]  sat_o
);
  localparam logic [39:0] MAX_V = 40'h7F_FFFF_FFFF;
  localparam logic [39:0] MIN_V = 40'h80_0000_0000;

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(acc_o) && $stable(ovf_o) && $stable(sat_o))); // R10

  AST_UNSEL_HOLD_A0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && acc_sel_i) |=> $stable(acc_o[39:0])); // R4

  AST_UNSEL_HOLD_A1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !acc_sel_i) |=> $stable(acc_o[79:40])); // R4

  AST_SAT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_o != 2'b00) |=> ((sat_o & $past(sat_o)) == $past(sat_o))); // R6

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o != 2'b00) |=> ((ovf_o & $past(ovf_o)) == $past(ovf_o))); // R9

  AST_NO_SAT_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sat_en_i) |=> $stable(sat_o)); // R7

  AST_SAT_AT_LIMIT_A0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sat_o[0]) |-> (acc_o[39:0] == MAX_V || acc_o[39:0] == MIN_V)); // R6

  AST_SAT_AT_LIMIT_A1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sat_o[1]) |-> (acc_o[79:40] == MAX_V || acc_o[79:40] == MIN_V)); // R6

  AST_SAT_HAS_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_o != 2'b00) |-> ((ovf_o & sat_o) == sat_o)); // R9

  AST_FRAC_NEG_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'b01 && !acc_sel_i && frac_i && a_signed_i && b_signed_i
     && a_i == 16'h8000 && b_i == 16'h8000) |=> (acc_o[39:0] == 40'h00_8000_0000)); // R3
endmodule

bind dsp_mac_engine dsp_mac_engine_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
  .acc_sel_i(acc_sel_i), .a_i(a_i), .b_i(b_i), .a_signed_i(a_signed_i),
  .b_signed_i(b_signed_i), .frac_i(frac_i), .sat_en_i(sat_en_i),
  .acc_o(acc_o), .ovf_o(ovf_o), .sat_o(sat_o)
);

// File: tb/dsp_mac_engine_bench.sv
module dsp_mac_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [1:0]  op = '0;
  logic        sel = 1'b0;
  logic [15:0] a = '0, b = '0;
  logic        as = 1'b0, bs = 1'b0, fr = 1'b0, sub = 1'b0, sat = 1'b0;
  logic [5:0]  amt = '0;
  logic [79:0] acc;
  logic [1:0]  ovf, satf;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [39:0] e_acc [2];
  logic [1:0]  e_ovf, e_sat;

  always #5 clk = ~clk;

  dsp_mac_engine u_dsp_mac_engine (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .acc_sel_i(sel),
    .a_i(a), .b_i(b), .a_signed_i(as), .b_signed_i(bs), .frac_i(fr), .sub_i(sub),
    .sat_en_i(sat), .shamt_i(amt), .acc_o(acc), .ovf_o(ovf), .sat_o(satf)
  );

  localparam logic [39:0] MAXV = 40'h7F_FFFF_FFFF;
  localparam logic [39:0] MINV = 40'h80_0000_0000;

  function automatic logic [39:0] m_prod(logic [15:0] x, logic [15:0] y,
                                         logic xs, logic ys, logic f);
    longint px, py, p;
    px = xs ? longint'($signed(x)) : longint'(x);
    py = ys ? longint'($signed(y)) : longint'(y);
    p  = px * py;
    if (f) p = p * 2;
    return p[39:0];
  endfunction

  function automatic logic [40:0] m_add(logic [39:0] x, logic [39:0] y,
                                        logic s, logic st);
    longint vx, vy, r;
    vx = longint'($signed(x));
    vy = longint'($signed(y));
    r  = s ? vx - vy : vx + vy;
    if (st && r > longint'(MAXV)) return {1'b1, MAXV};
    if (st && r < -longint'(MAXV) - 1) return {1'b1, MINV};
    return {1'b0, r[39:0]};
  endfunction

  function automatic logic [40:0] m_shift(logic [39:0] x, int n, logic st);
    int m;
    longint w;
    m = (n < 0) ? -n : n;
    if (m > 16) m = 16;
    w = longint'($signed(x));
    if (n >= 0) begin
      w = w >>> m;
      return {1'b0, w[39:0]};
    end
    w = w * (longint'(1) << m);
    if (st && w > longint'(MAXV)) return {1'b1, MAXV};
    if (st && w < -longint'(MAXV) - 1) return {1'b1, MINV};
    return {1'b0, w[39:0]};
  endfunction

  function automatic bit guard_bad(logic [39:0] v);
    return !(v[39:31] == 9'h000 || v[39:31] == 9'h1FF);
  endfunction

  task automatic check(string req);
    tests++;
    if (acc !== {e_acc[1], e_acc[0]} || ovf !== e_ovf || satf !== e_sat) begin
      fails++;
      $display("FAIL %s: acc=%h ovf=%b sat=%b expected acc=%h ovf=%b sat=%b",
               req, acc, ovf, satf, {e_acc[1], e_acc[0]}, e_ovf, e_sat);
    end
  endtask

  task automatic do_op(logic [1:0] o, logic s, logic [15:0] x, logic [15:0] y,
                       logic xs, logic ys, logic f, logic sb, logic st, int n,
                       string req);
    logic [40:0] r;
    @(negedge clk);
    valid = 1'b1; op = o; sel = s; a = x; b = y; as = xs; bs = ys;
    fr = f; sub = sb; sat = st; amt = n[5:0];
    case (o)
      2'b01:   r = {1'b0, m_prod(x, y, xs, ys, f)};
      2'b00:   r = m_add(e_acc[s], m_prod(x, y, xs, ys, f), sb, st);
      2'b10:   r = m_add(e_acc[s], e_acc[~s], sb, st);
      default: r = m_shift(e_acc[s], n, st);
    endcase
    @(posedge clk);
    e_acc[s] = r[39:0];
    if (guard_bad(r[39:0])) e_ovf[s] = 1'b1;
    if (r[40]) e_sat[s] = 1'b1;
    #1 check(req);
  endtask

  task automatic idle(int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      valid = 1'b0; op = 2'(i); sel = 1'(i); a = 16'h7FFF; b = 16'h7FFF;
      sat = 1'b1; amt = 6'h30;
      @(posedge clk);
      #1 check("R10 idle hold");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    e_acc[0] = '0; e_acc[1] = '0; e_ovf = '0; e_sat = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset state");
    rst_n = 1'b1;

    // R2: signedness mixes, integer mode
    do_op(2'b01, 0, 16'hFFFF, 16'h0003, 1, 1, 0, 0, 0, 0, "R2 signed x signed");
    do_op(2'b01, 0, 16'hFFFF, 16'hFFFF, 0, 0, 0, 0, 0, 0, "R2 unsigned x unsigned");
    do_op(2'b01, 1, 16'hFFFF, 16'hFFFF, 1, 0, 0, 0, 0, 0, "R2 mixed sign");
    // R3: fractional -1 x -1
    do_op(2'b01, 0, 16'h8000, 16'h8000, 1, 1, 1, 0, 0, 0, "R3 frac -1 x -1");
    do_op(2'b01, 1, 16'h4000, 16'hC000, 1, 1, 1, 0, 0, 0, "R3 frac 0.5 x -0.5");
    // R4: accumulate / subtract
    do_op(2'b00, 1, 16'h1234, 16'h0100, 1, 1, 0, 0, 0, 0, "R4 mac add");
    do_op(2'b00, 1, 16'h7FFF, 16'h7FFF, 1, 1, 1, 1, 0, 0, "R4 mac subtract");
    // R5: accumulator add / subtract
    do_op(2'b10, 0, 16'h0, 16'h0, 0, 0, 0, 0, 0, 0, "R5 acc add");
    do_op(2'b10, 1, 16'h0, 16'h0, 0, 0, 0, 1, 0, 0, "R5 acc subtract");
    // R8: shift clamping of magnitude
    do_op(2'b11, 0, 16'h0, 16'h0, 0, 0, 0, 0, 0, 31, "R8 right shift clamp 16");
    do_op(2'b11, 0, 16'h0, 16'h0, 0, 0, 0, 0, 0, -32, "R8 left shift clamp 16");
    do_op(2'b11, 1, 16'h0, 16'h0, 0, 0, 0, 0, 0, 3, "R8 arithmetic right");
    // R7: wrap without saturation on acc1
    do_op(2'b01, 1, 16'hFFFF, 16'hFFFF, 0, 0, 1, 0, 0, 0, "R2 unsigned frac");
    do_op(2'b11, 1, 16'h0, 16'h0, 0, 0, 0, 0, 0, -6, "R8 left shift in range");
    do_op(2'b00, 1, 16'hFFFF, 16'hFFFF, 0, 0, 1, 0, 0, 0, "R7 mac wraps");
    // R6: saturation on acc0
    do_op(2'b01, 0, 16'h7FFF, 16'h7FFF, 1, 1, 1, 0, 1, 0, "R2 max square");
    do_op(2'b11, 0, 16'h0, 16'h0, 0, 0, 0, 0, 1, -16, "R6 left shift saturates");
    do_op(2'b00, 0, 16'h7FFF, 16'h7FFF, 1, 1, 1, 0, 1, 0, "R6 mac holds max");
    do_op(2'b00, 0, 16'h7FFF, 16'h7FFF, 1, 1, 1, 1, 1, 0, "R6 mac leaves max");
    do_op(2'b11, 1, 16'h0, 16'h0, 0, 0, 0, 0, 1, -16, "R6 negative left saturates");
    idle(4);

    for (int i = 0; i < 600; i++) begin
      int n;
      logic [1:0] o;
      o = 2'($urandom);
      n = int'($urandom_range(0, 63)) - 32;
      do_op(o, 1'($urandom), 16'($urandom), 16'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), n,
            o == 2'b00 ? "R4 random mac" : o == 2'b01 ? "R2 random mpy" :
            o == 2'b10 ? "R5 random add" : "R8 random shift");
      if (i % 97 == 0) idle(2);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule